// File: doc/BRIEF.md
# Flash Write-Status Polling Register

This block forms the byte a host sees when it reads a flash device while an embedded program or erase is running. A program or erase controller supplies the current operation mode, whether the read address falls in a sector being erased or suspended, whether the sector-load window is still open, and whether the operation has run past its time limit. It also supplies the most recent byte being programmed. The block answers each host read with a polling byte or, where the address is not affected, with the array data passed through.

Two bits, the operation toggle and the sector toggle, flip once on each rising edge of the read strobe. A host that reads twice in a row while the device is busy therefore sees different values. When two reads return the same toggle bit and the data-polling bit shows true data, the operation has finished. The ready/busy output follows the mode directly and needs no read.

Top module: `fsp_status_top`

## Requirements
- R1: After reset, `dout` is all zeros and both toggle bits start at 0. The first busy read therefore returns 0 in bits 6 and 2.
- R2: In program mode (`mode`=1), bit 7 of the returned byte is the complement of `prog_data[7]`, bit 3 is 0, bit 2 holds its previous value, and `ry_by` is 0.
- R3: In modes 1, 2 and 4, bit 6 of the returned byte has the opposite value on each successive read.
- R4: In erase mode (`mode`=2), bit 7 is 0, `ry_by` is 0, and bit 3 is 1 once `win_open` is low and 0 while it is high.
- R5: Bit 2 flips on each read in mode 2 or mode 3 when `in_sec` is 1. It keeps its value on reads in every other case.
- R6: In erase-suspend read (`mode`=3) with `in_sec`=1, bit 7 is 1, bit 6 keeps its previous value, bit 5 is 0, and `ry_by` is 1.
- R7: In idle mode (`mode`=0, and the unused codes 5 to 7), and in mode 3 with `in_sec`=0, `dout` equals `array_data` sampled at the read, and `ry_by` is 1.
- R8: In erase-suspend program (`mode`=4), bit 7 is the complement of `prog_data[7]`, bit 3 is 0, and `ry_by` is 0.
- R9: In modes 1, 2 and 4, bit 5 equals `tlim` sampled at the read. Bits 4, 1 and 0 of every polling byte are 0.
- R10: `dout` changes only on the clock edge where `rd_strobe` is first seen high. Holding the strobe high counts as one read, and `dout` does not follow input changes while it is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Operation: 0 idle, 1 program, 2 erase, 3 suspend-read, 4 suspend-program |
| in_sec | input | 1 | Read address lies in an erasing or suspended sector |
| win_open | input | 1 | Sector-load window still open |
| tlim | input | 1 | Operation exceeded its time limit |
| prog_data | input | DATA_W | Byte currently being programmed |
| array_data | input | DATA_W | Array contents at the read address |
| rd_strobe | input | 1 | Host read strobe, level signal |
| dout | output | DATA_W | Registered read result |
| ry_by | output | 1 | High when ready, low when busy |

## Verification
A read result is due one clock edge after the read is requested. The edge on which `rd_strobe` is first sampled high both loads `dout` and flips the toggle bits, so the result is compared at the next falling edge. `ry_by` is combinational from `mode` and is checked a short delay after the inputs change, before any clock edge. The driver queues each expected byte at the moment it raises the strobe. The monitor detects the same strobe rise on its own, then pops and compares the byte at the falling edge that follows. Held-strobe reads are additionally checked on every following falling edge while the strobe stays high.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_PROG    = 3'd1,
    OP_ERASE   = 3'd2,
    OP_SUSP_RD = 3'd3,
    OP_SUSP_PG = 3'd4
  } op_mode_e;

  localparam int STAT_W  = 8;
  localparam int B_POLL  = 7;
  localparam int B_TOG   = 6;
  localparam int B_TLIM  = 5;
  localparam int B_WIN   = 3;
  localparam int B_STOG  = 2;
  localparam int N_TOG   = 2;
  localparam int T_OP    = 0;
  localparam int T_SEC   = 1;

  function automatic op_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd1:    return OP_PROG;
      3'd2:    return OP_ERASE;
      3'd3:    return OP_SUSP_RD;
      3'd4:    return OP_SUSP_PG;
      default: return OP_IDLE;
    endcase
  endfunction

  function automatic logic is_busy(input op_mode_e m);
    return (m == OP_PROG) || (m == OP_ERASE) || (m == OP_SUSP_PG);
  endfunction

  function automatic logic op_toggles(input op_mode_e m);
    return is_busy(m);
  endfunction

  function automatic logic sec_toggles(input op_mode_e m, input logic in_sec);
    return in_sec && ((m == OP_ERASE) || (m == OP_SUSP_RD));
  endfunction

  function automatic logic shows_array(input op_mode_e m, input logic in_sec);
    return (m == OP_IDLE) || ((m == OP_SUSP_RD) && !in_sec);
  endfunction

  function automatic logic [STAT_W-1:0] build_status(
    input op_mode_e m,
    input logic     win_open,
    input logic     tlim,
    input logic     pd7,
    input logic     tog_op,
    input logic     tog_sec
  );
    logic [STAT_W-1:0] s;
    s = '0;
    s[B_TOG]  = tog_op;
    s[B_STOG] = tog_sec;
    case (m)
      OP_PROG, OP_SUSP_PG: begin
        s[B_POLL] = ~pd7;
        s[B_TLIM] = tlim;
      end
      OP_ERASE: begin
        s[B_POLL] = 1'b0;
        s[B_TLIM] = tlim;
        s[B_WIN]  = ~win_open;
      end
      OP_SUSP_RD: begin
        s[B_POLL] = 1'b1;
      end
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/fsp_read_edge.sv
module fsp_read_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/fsp_toggle_bit.sv
module fsp_toggle_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (flip) q <= ~q;
  end
endmodule

// File: rtl/fsp_status_build.sv
module fsp_status_build
  import fsp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_mode_e          op,
  input  logic              in_sec,
  input  logic              win_open,
  input  logic              tlim,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [DATA_W-1:0] array_data,
  input  logic [N_TOG-1:0]  tog_q,
  output logic [DATA_W-1:0] next_byte
);
  localparam int PAD_W = DATA_W - STAT_W;

  logic [STAT_W-1:0] stat;

  always_comb begin
    stat = build_status(op, win_open, tlim, prog_data[B_POLL],
                        tog_q[T_OP], tog_q[T_SEC]);
    if (shows_array(op, in_sec)) next_byte = array_data;
    else                         next_byte = {{PAD_W{1'b0}}, stat};
  end
endmodule

// File: rtl/fsp_status_top.sv
module fsp_status_top
  import fsp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              in_sec,
  input  logic              win_open,
  input  logic              tlim,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [DATA_W-1:0] array_data,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] dout,
  output logic              ry_by
);
  op_mode_e          op;
  logic              rd_rise;
  logic [N_TOG-1:0]  tog_flip;
  logic [N_TOG-1:0]  tog_q;
  logic              q6_tog;
  logic              q2_tog;
  logic [DATA_W-1:0] next_byte;

  assign op = decode_mode(mode);

  fsp_read_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (rd_strobe),
    .rise   (rd_rise)
  );

  always_comb begin
    tog_flip        = '0;
    tog_flip[T_OP]  = rd_rise & op_toggles(op);
    tog_flip[T_SEC] = rd_rise & sec_toggles(op, in_sec);
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_TOG; gi++) begin : g_tog
      fsp_toggle_bit u_tog (
        .clk   (clk),
        .rst_n (rst_n),
        .flip  (tog_flip[gi]),
        .q     (tog_q[gi])
      );
    end
  endgenerate

  assign q6_tog = tog_q[T_OP];
  assign q2_tog = tog_q[T_SEC];

  fsp_status_build #(.DATA_W(DATA_W)) u_build (
    .op         (op),
    .in_sec     (in_sec),
    .win_open   (win_open),
    .tlim       (tlim),
    .prog_data  (prog_data),
    .array_data (array_data),
    .tog_q      (tog_q),
    .next_byte  (next_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout <= '0;
    else if (rd_rise) dout <= next_byte;
  end

  assign ry_by = ~is_busy(op);
endmodule

// File: rtl/fsp_chk.sv
module fsp_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic              in_sec,
  input logic              win_open,
  input logic [DATA_W-1:0] prog_data,
  input logic [DATA_W-1:0] array_data,
  input logic              rd_rise,
  input logic              q6_tog,
  input logic              q2_tog,
  input logic [DATA_W-1:0] dout
);
  // R10
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rise |=> $stable(dout));

  // R3
  op_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && (mode == 3'd1 || mode == 3'd2 || mode == 3'd4)) |=> (q6_tog != $past(q6_tog)));

  // R5
  sec_toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rise |=> ($stable(q2_tog) && $stable(q6_tog)));

  // R2
  prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && mode == 3'd1) |=> (dout[7] == !$past(prog_data[7])));

  // R4
  erase_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && mode == 3'd2) |=> (!dout[7] && dout[3] == !$past(win_open)));

  // R6
  susp_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && mode == 3'd3 && in_sec) |=> (dout[7] && $stable(q6_tog)));

  // R7
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && mode == 3'd0) |=> (dout == $past(array_data)));
endmodule

bind fsp_status_top fsp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .in_sec     (in_sec),
  .win_open   (win_open),
  .prog_data  (prog_data),
  .array_data (array_data),
  .rd_rise    (rd_rise),
  .q6_tog     (q6_tog),
  .q2_tog     (q2_tog),
  .dout       (dout)
);

// File: tb/test_fsp_status_top.sv
module test_fsp_status_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       in_sec = 1'b0;
  logic       win_open = 1'b0;
  logic       tlim = 1'b0;
  logic [7:0] prog_data = 8'h00;
  logic [7:0] array_data = 8'h00;
  logic       rd_strobe = 1'b0;
  logic [7:0] dout;
  logic       ry_by;

  int checks = 0;
  int errors = 0;
  logic b6 = 1'b0;
  logic b2 = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  fsp_status_top #(.DATA_W(8)) i_fsp_status_top (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_sec(in_sec),
    .win_open(win_open), .tlim(tlim), .prog_data(prog_data),
    .array_data(array_data), .rd_strobe(rd_strobe),
    .dout(dout), .ry_by(ry_by)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [2:0] m, input logic s,
                                       input logic w, input logic t,
                                       input logic [7:0] pd, input logic [7:0] ad);
    case (m)
      3'd1, 3'd4: return {~pd[7], b6, t, 1'b0, 1'b0, b2, 2'b00};
      3'd2:       return {1'b0, b6, t, 1'b0, ~w, b2, 2'b00};
      3'd3:       return s ? {1'b1, b6, 1'b0, 1'b0, 1'b0, b2, 2'b00} : ad;
      default:    return ad;
    endcase
  endfunction

  task automatic do_read(input logic [2:0] m, input logic s, input logic w,
                         input logic t, input logic [7:0] pd, input logic [7:0] ad,
                         input int hold, input string req);
    logic [7:0] e;
    logic       busy;
    @(negedge clk);
    mode = m; in_sec = s; win_open = w; tlim = t; prog_data = pd; array_data = ad;
    rd_strobe = 1'b1;
    e = model(m, s, w, t, pd, ad);
    exp_q.push_back(e);
    tag_q.push_back(req);
    if (m == 3'd1 || m == 3'd2 || m == 3'd4) b6 = ~b6;
    if (s && (m == 3'd2 || m == 3'd3)) b2 = ~b2;
    busy = (m == 3'd1 || m == 3'd2 || m == 3'd4);
    #1;
    check8({req, " ry_by"}, {7'd0, ry_by}, {7'd0, ~busy});
    @(negedge clk);
    for (int i = 1; i < hold; i++) begin
      array_data = ~array_data;
      prog_data  = ~prog_data;
      @(negedge clk);
      check8("R10 held strobe", dout, e);
    end
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  // monitor: detects each strobe rise itself and compares after that edge
  initial begin
    logic prev = 1'b0;
    forever begin
      @(posedge clk);
      if (rd_strobe && !prev && rst_n) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          errors++;
          checks++;
          $display("FAIL R10: unexpected read, actual %02h expected none", dout);
        end else begin
          check8(tag_q.pop_front(), dout, exp_q.pop_front());
        end
        prev = 1'b1;
      end else begin
        prev = rd_strobe;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check8("R1 reset dout", dout, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check8("R1 reset dout after release", dout, 8'h00);

    // program
    do_read(3'd1, 1'b0, 1'b0, 1'b0, 8'h80, 8'h55, 1, "R1 R2 program first read");
    do_read(3'd1, 1'b0, 1'b0, 1'b0, 8'h7F, 8'h55, 1, "R2 R3 program");
    do_read(3'd1, 1'b1, 1'b0, 1'b1, 8'h80, 8'h55, 1, "R9 program time limit");
    // erase
    do_read(3'd2, 1'b1, 1'b1, 1'b0, 8'h00, 8'hAA, 1, "R4 R5 erase window open");
    do_read(3'd2, 1'b1, 1'b0, 1'b0, 8'h00, 8'hAA, 1, "R4 R5 erase window closed");
    do_read(3'd2, 1'b0, 1'b0, 1'b1, 8'h00, 8'hAA, 1, "R5 R9 erase outside sector");
    // suspend read
    do_read(3'd3, 1'b1, 1'b0, 1'b1, 8'h00, 8'h3C, 1, "R6 suspend read in sector");
    do_read(3'd3, 1'b1, 1'b0, 1'b0, 8'h00, 8'h3C, 1, "R6 R5 suspend read again");
    do_read(3'd3, 1'b0, 1'b0, 1'b0, 8'h00, 8'hC3, 1, "R7 suspend read other sector");
    // suspend program
    do_read(3'd4, 1'b0, 1'b0, 1'b0, 8'h00, 8'h11, 1, "R8 suspend program");
    do_read(3'd4, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h11, 1, "R8 R9 suspend program limit");
    // idle and unused code
    do_read(3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h96, 1, "R7 idle pass-through");
    do_read(3'd6, 1'b1, 1'b0, 1'b1, 8'h00, 8'h69, 1, "R7 unused mode code");
    // held strobe: one read only
    do_read(3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h5A, 4, "R10 idle held");
    do_read(3'd1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3, "R10 R3 program held");
    do_read(3'd1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1, "R10 R3 program after hold");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10: actual %0d pending reads expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule